// File: doc/BRIEF.md
# Programmable Interrupt Allocation Controller

The block sits between eight interrupt-request sources (an A/D converter done flag, a serial port, three timers and three external hardware pins) and a processor core that has three internal interrupt lines of falling priority. Software programs one allocation register. Two 4-bit select fields each pick which single source drives the top line and the middle line. Eight enable bits decide which of the remaining sources are merged onto the bottom line. A source that is neither picked nor enabled can never interrupt the core.

Each request input is edge-captured into a sticky pending bit. The pending bits can be read at any time through a status register, which lets the bottom-line handler find out which of its merged sources fired and lets software poll with all lines off. A pending bit is cleared either by writing a 1 to its status bit or by acknowledging the line that currently owns that source. Every interrupt output is a registered level.

Top module: `irq_alloc_ctrl`

## Requirements
- R1: Allocation bits [3:0] select the source of `irq_out[0]`, and bits [7:4] select the source of `irq_out[1]`. Codes 0 to 7 name source index 0 to 7: 0 A/D done, 1 serial port, 2 timer 0, 3 timer 1, 4 timer 2, 5 external 0, 6 external 1, 7 external 2. The source index is also its `src_req` bit. Any code from 8 to 15 turns that line off.
- R2: When both select fields name the same source, `irq_out[0]` alone owns it, and `irq_out[1]` never goes high for it.
- R3: Allocation bit 8+i enables source i for the pool line `irq_out[2]` (1 enables it). Every enabled source that is not owned by line 0 or line 1 is ORed onto `irq_out[2]`.
- R4: A source that is neither selected for line 0 or line 1 nor enabled raises no interrupt output.
- R5: A rising edge on `src_req[i]` sets pending bit i. That bit stays set after the input falls, until one of the clears in R6 or R7. The status register (address 1) shows pending bit i at data bit i, whatever the enable bits are.
- R6: Writing the status register clears every pending bit whose data bit is 1 and leaves the bits written as 0 untouched. A rising edge in the same cycle as a clear wins, and the bit stays set.
- R7: A pulse on `irq_ack[k]` clears the pending bits of the sources that line k owns. It does not touch sources owned by other lines or by no line.
- R8: After reset the allocation register, all pending bits and all outputs are 0. Source 0 is then routed to `irq_out[0]` only, and every other source is silent.
- R9: Address 0 is the 16-bit allocation register, which can be written and read back. A read returns the value of the register at `reg_addr` on the clock edge after the address is presented.
- R10: `irq_out[k]` is high exactly one clock edge after some source that line k owns has its pending bit set. A rising input therefore shows on its line at the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 allocation, 1 status |
| reg_wr_data | input | 16 | Write data |
| reg_rd_data | output | 16 | Registered read data for the register at `reg_addr` |
| src_req | input | 8 | Interrupt request inputs, one per source |
| irq_ack | input | 3 | Per-line acknowledge pulses |
| irq_out | output | 3 | Interrupt lines: 0 highest priority, 2 the merged pool |

## Verification
A wrong routing decode shows up two edges after a source rises: the wrong line goes high, no line goes high, or two lines go high at once. So the bench sweeps every pair of select codes under several enable patterns and every source, and predicts the line from the codes arithmetically. A pending bit that is lost or stuck shows up one edge later in the status read. It also shows up after an acknowledge: the status bit must clear only when the owning line is acknowledged.

// File: rtl/irq_alloc_pkg.sv
package irq_alloc_pkg;

  localparam int LINE_CNT = 3;

  typedef enum logic [1:0] {
    LINE_TOP  = 2'd0,
    LINE_MID  = 2'd1,
    LINE_POOL = 2'd2
  } line_e;

  typedef enum logic {
    ADDR_ALLOC  = 1'b0,
    ADDR_STATUS = 1'b1
  } reg_addr_e;

endpackage

// File: rtl/irq_alloc_regs.sv
module irq_alloc_regs #(
  parameter int NUM_SRC = 8,
  parameter int REG_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [NUM_SRC-1:0] pending,
  output logic [REG_W-1:0]   alloc_q,
  output logic [NUM_SRC-1:0] w1c_vec,
  output logic [REG_W-1:0]   rd_data_q
);
  import irq_alloc_pkg::*;

  logic [REG_W-1:0] status_view;

  always_comb begin
    status_view = '0;
    status_view[NUM_SRC-1:0] = pending;
  end

  always_comb begin
    w1c_vec = '0;
    if (wr_en && (addr == ADDR_STATUS)) w1c_vec = wr_data[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_q <= '0;
    end else if (wr_en && (addr == ADDR_ALLOC)) begin
      alloc_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
    end else begin
      rd_data_q <= (addr == ADDR_STATUS) ? status_view : alloc_q;
    end
  end

endmodule

// File: rtl/irq_alloc_route.sv
module irq_alloc_route #(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 4,
  parameter int REG_W   = 16
) (
  input  logic [REG_W-1:0]                               alloc,
  input  logic [irq_alloc_pkg::LINE_CNT-1:0]             ack,
  input  logic [NUM_SRC-1:0]                             w1c_vec,
  output logic [irq_alloc_pkg::LINE_CNT-1:0][NUM_SRC-1:0] route,
  output logic [NUM_SRC-1:0]                             clr_vec
);
  import irq_alloc_pkg::*;

  localparam int ENA_LSB = 2 * SEL_W;

  logic [SEL_W-1:0]   sel_top;
  logic [SEL_W-1:0]   sel_mid;
  logic               top_ok;
  logic               mid_ok;
  logic [NUM_SRC-1:0] ena;
  logic [NUM_SRC-1:0] ack_hit;

  assign sel_top = alloc[SEL_W-1:0];
  assign sel_mid = alloc[2*SEL_W-1:SEL_W];
  assign ena     = alloc[ENA_LSB +: NUM_SRC];
  assign top_ok  = (int'(sel_top) < NUM_SRC);
  assign mid_ok  = (int'(sel_mid) < NUM_SRC);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic own_top;
    logic own_mid;
    assign own_top = top_ok && (sel_top == SEL_W'(i));
    assign own_mid = mid_ok && (sel_mid == SEL_W'(i)) && !own_top;
    assign route[LINE_TOP][i]  = own_top;
    assign route[LINE_MID][i]  = own_mid;
    assign route[LINE_POOL][i] = ena[i] && !own_top && !own_mid;
    assign ack_hit[i] = (ack[LINE_TOP]  && own_top) ||
                        (ack[LINE_MID]  && own_mid) ||
                        (ack[LINE_POOL] && route[LINE_POOL][i]);
  end

  assign clr_vec = ack_hit | w1c_vec;

endmodule

// File: rtl/irq_alloc_pend.sv
module irq_alloc_pend #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] pend_q
);

  logic [NUM_SRC-1:0] req_prev_q;
  logic [NUM_SRC-1:0] rise;

  assign rise = req & ~req_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev_q <= '0;
      pend_q     <= '0;
    end else begin
      req_prev_q <= req;
      pend_q     <= (pend_q & ~clr_vec) | rise;
    end
  end

endmodule

// File: rtl/irq_alloc_lines.sv
module irq_alloc_lines #(
  parameter int NUM_SRC = 8
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic [NUM_SRC-1:0]                             pending,
  input  logic [irq_alloc_pkg::LINE_CNT-1:0][NUM_SRC-1:0] route,
  output logic [irq_alloc_pkg::LINE_CNT-1:0]             irq_q
);
  import irq_alloc_pkg::*;

  for (genvar k = 0; k < LINE_CNT; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) irq_q[k] <= 1'b0;
      else     irq_q[k] <= |(pending & route[k]);
    end
  end

endmodule

// File: rtl/irq_alloc_ctrl.sv
module irq_alloc_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = $clog2(NUM_SRC) + 1,
  parameter int REG_W   = 2 * SEL_W + NUM_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic               reg_addr,
  input  logic [REG_W-1:0]   reg_wr_data,
  output logic [REG_W-1:0]   reg_rd_data,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [2:0]         irq_ack,
  output logic [2:0]         irq_out
);
  import irq_alloc_pkg::*;

  logic [REG_W-1:0]                alloc_q;
  logic [NUM_SRC-1:0]              w1c_vec;
  logic [NUM_SRC-1:0]              clr_vec;
  logic [NUM_SRC-1:0]              pend_q;
  logic [LINE_CNT-1:0][NUM_SRC-1:0] route_mask;

  irq_alloc_regs #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wr_data   (reg_wr_data),
    .pending   (pend_q),
    .alloc_q   (alloc_q),
    .w1c_vec   (w1c_vec),
    .rd_data_q (reg_rd_data)
  );

  irq_alloc_route #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .REG_W(REG_W)) u_route (
    .alloc   (alloc_q),
    .ack     (irq_ack),
    .w1c_vec (w1c_vec),
    .route   (route_mask),
    .clr_vec (clr_vec)
  );

  irq_alloc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .req     (src_req),
    .clr_vec (clr_vec),
    .pend_q  (pend_q)
  );

  irq_alloc_lines #(.NUM_SRC(NUM_SRC)) u_lines (
    .clk     (clk),
    .rst     (rst),
    .pending (pend_q),
    .route   (route_mask),
    .irq_q   (irq_out)
  );

endmodule

// File: rtl/irq_alloc_chk.sv
module irq_alloc_chk #(
  parameter int NUM_SRC = 8,
  parameter int REG_W   = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   reg_wr_en,
  input logic                   reg_addr,
  input logic [REG_W-1:0]       reg_wr_data,
  input logic [NUM_SRC-1:0]     src_req,
  input logic [2:0]             irq_ack,
  input logic [2:0]             irq_out,
  input logic [REG_W-1:0]       alloc,
  input logic [NUM_SRC-1:0]     pending,
  input logic [2:0][NUM_SRC-1:0] route
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (irq_out == 3'b000 && pending == '0 && alloc == '0)); // R8

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic owned_ack;
    assign owned_ack = (irq_ack[0] && route[0][i]) ||
                       (irq_ack[1] && route[1][i]) ||
                       (irq_ack[2] && route[2][i]);

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
      $onehot0({route[0][i], route[1][i], route[2][i]})); // R2

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
      $rose(src_req[i]) |=> pending[i]); // R5

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (pending[i] && !(reg_wr_en && reg_addr && reg_wr_data[i]) && !owned_ack)
      |=> pending[i]); // R5

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (reg_wr_en && reg_addr && reg_wr_data[i] && !src_req[i]) |=> !pending[i]); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (owned_ack && !src_req[i]) |=> !pending[i]); // R7
  end

  for (genvar k = 0; k < 3; k++) begin : g_ln
    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
      ((pending & route[k]) == '0) |=> !irq_out[k]); // R4

    AST_LINE_RAISE: assert property (@(posedge clk) disable iff (rst)
      ((pending & route[k]) != '0) |=> irq_out[k]); // R10
  end

endmodule

bind irq_alloc_ctrl irq_alloc_chk #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wr_data (reg_wr_data),
  .src_req     (src_req),
  .irq_ack     (irq_ack),
  .irq_out     (irq_out),
  .alloc       (alloc_q),
  .pending     (pend_q),
  .route       (route_mask)
);

// File: tb/irq_alloc_ctrl_tb.sv
`timescale 1ns/1ps
module irq_alloc_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic        reg_addr = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic [7:0]  src_req = '0;
  logic [2:0]  irq_ack = '0;
  logic [2:0]  irq_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  irq_alloc_ctrl u_dut (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .src_req     (src_req),
    .irq_ack     (irq_ack),
    .irq_out     (irq_out)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [15:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    step();
    reg_wr_en = 1'b0;
  endtask

  task automatic pulse(logic [7:0] s);
    src_req = s;
    step();
    src_req = '0;
  endtask

  // line that owns source i: 0,1,2, or 3 for none
  function automatic int owner(int s0, int s1, int en, int i);
    if (s0 < 8 && s0 == i) return 0;
    if (s1 < 8 && s1 == i) return 1;
    if (((en >> i) & 1) == 1) return 2;
    return 3;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int en_set [3] = '{8'h00, 8'hFF, 8'h5A};
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    // R8 reset state
    reg_addr = 1'b0; step();
    chk("R8 irq after reset", irq_out, 0);
    chk("R8 alloc after reset", reg_rd_data, 0);
    reg_addr = 1'b1; step();
    chk("R8 status after reset", reg_rd_data, 0);
    // R8 default routing: source 0 to line 0 only, source 1 silent
    pulse(8'h03); step();
    chk("R8 default routing", irq_out, 3'b001);
    chk("R5 status both pending", reg_rd_data, 16'h0003);
    // R5 sticky over many cycles
    repeat (10) step();
    chk("R5 sticky line", irq_out, 3'b001);
    // R7 ack of non-owning lines has no effect
    irq_ack = 3'b110; step(); irq_ack = '0; step();
    chk("R7 foreign ack ignored", irq_out, 3'b001);
    chk("R7 foreign ack status", reg_rd_data, 16'h0003);
    // R6 write of zero bits leaves pending; write of 1 clears only that bit
    wr(1'b1, 16'h0000); step();
    chk("R6 zero write no effect", reg_rd_data, 16'h0003);
    wr(1'b1, 16'h0002); step();
    chk("R6 single bit clear", reg_rd_data, 16'h0001);
    chk("R6 line still up", irq_out, 3'b001);
    // R6 edge wins over simultaneous clear
    reg_wr_en = 1'b1; reg_addr = 1'b1; reg_wr_data = 16'h0004; src_req = 8'h04;
    step();
    reg_wr_en = 1'b0; src_req = '0;
    step();
    chk("R6 set wins", reg_rd_data, 16'h0005);
    wr(1'b1, 16'h00FF); step();
    chk("R6 clear all", reg_rd_data, 16'h0000);
    // R9 readback
    wr(1'b0, 16'hA53C); reg_addr = 1'b0; step();
    chk("R9 alloc readback", reg_rd_data, 16'hA53C);
    // R10 pool OR: lines off, enable sources 2 and 5
    wr(1'b0, 16'h24FF); reg_addr = 1'b1;
    pulse(8'h24); step();
    chk("R10 pool high two sources", irq_out, 3'b100);
    wr(1'b1, 16'h0004); step();
    chk("R10 pool held by remaining", irq_out, 3'b100);
    wr(1'b1, 16'h0020); step();
    chk("R10 pool drops", irq_out, 3'b000);
    // R10 exact latency: not high after first edge, high after second
    src_req = 8'h20; @(posedge clk); @(negedge clk); src_req = '0;
    chk("R10 not yet at first edge", irq_out, 3'b000);
    step();
    chk("R10 high at second edge", irq_out, 3'b100);
    wr(1'b1, 16'h00FF); step();

    // R1 R2 R3 R4 R7 sweep over all select pairs, several enable sets, all sources
    for (int s0 = 0; s0 < 16; s0++) begin
      for (int s1 = 0; s1 < 16; s1++) begin
        for (int e = 0; e < 3; e++) begin
          for (int i = 0; i < 8; i++) begin
            int ln;
            ln = owner(s0, s1, en_set[e], i);
            wr(1'b0, 16'((en_set[e] << 8) | (s1 << 4) | s0));
            wr(1'b1, 16'h00FF);
            reg_addr = 1'b1;
            pulse(8'(1 << i));
            step();
            chk((ln == 3) ? "R4 unrouted silent" :
                (ln == 2) ? "R3 pool routing" :
                (s0 == s1) ? "R2 shared select" : "R1 select routing",
                irq_out, (ln == 3) ? 0 : (1 << ln));
            chk("R5 status pending", reg_rd_data, 1 << i);
            irq_ack = (ln == 3) ? 3'b111 : 3'(1 << ln);
            step();
            irq_ack = '0;
            step();
            chk("R7 ack result irq", irq_out, 0);
            chk("R7 ack result status", reg_rd_data, (ln == 3) ? (1 << i) : 0);
          end
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule